// File: doc/BRIEF.md
# Outbound Address Translation Window Bank

This block holds a small bank of outbound windows that carry processor-local addresses over to PCI bus addresses. Software programs each window through a 32-bit register port. A fully programmable window has a 64-bit local base, a 64-bit PCI base and a 32-bit size word. The size word does two jobs: bit 0 enables the window, and the remaining bits are a mask whose two's complement gives the window length. The last window in the bank exposes only its size word. That word can be stored and read back, but it never translates.

A lookup presents a 64-bit local address. One clock later the block reports one of two results. On a hit it gives the index of the lowest-numbered enabled window that covers the address, together with the translated PCI address. Otherwise it raises a no-hit flag. The bus cycle that follows a lookup is the job of the surrounding logic.

Top module: `obwin_xlate`

## Requirements
- R1: After reset every window register reads zero and every lookup misses.
- R2: Each full window w occupies five 32-bit registers starting at byte offset 0x68 + 0x14*w, in this order: local base bits 31:0, local base bits 63:32, size word, PCI base bits 31:0, PCI base bits 63:32. Writing one half of a 64-bit base replaces only that half and leaves the other half unchanged.
- R3: A read with `reg_valid` high and `reg_write` low returns the addressed register on `reg_rdata` in the same cycle. Reads of unmapped offsets return zero, and writes to unmapped offsets change no register.
- R4: A window whose size word has bit 0 clear matches no address.
- R5: The window length is the 32-bit two's complement of the size word with bit 0 forced to zero. A result of zero means a length of 0xFFFFFFFF. An address hits when base <= addr < base + length.
- R6: On a hit, `res_pci` equals PCI base + (addr - local base), taken modulo 2^64.
- R7: When several enabled windows cover an address, the lowest index wins.
- R8: The size word of the last window sits at offset 0x68 + 0x14*NFULL (0x90 by default). It is stored and read back, but it never produces a hit.
- R9: The lookup result appears one cycle after `xl_valid`. When `res_valid` is high, exactly one of `res_hit` and `res_miss` is high. When `res_valid` is low, both are low, and on a miss `res_win` and `res_pci` are zero.
- R10: A lookup issued in the same cycle as a register write is judged against the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the read |
| xl_valid | input | 1 | Lookup request |
| xl_addr | input | 64 | Local address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | An enabled window matched |
| res_miss | output | 1 | No window matched |
| res_win | output | 2 | Index of the winning window |
| res_pci | output | 64 | Translated PCI address |

## Verification
A register write and a lookup can land in the same cycle. When the write touches the window the lookup needs, the result depends on which contents the lookup sees. The bench provokes this by driving an enabling size-word write and a lookup on the same edge. It expects a miss for that lookup and a hit for the lookup one cycle later. It repeats the pair with a write that disables a live window, and there it expects a hit followed by a miss.

// File: rtl/obwin_xlate.sv
module obwin_xlate #(
  parameter int       NFULL     = 2,
  parameter bit [7:0] FIRST_OFS = 8'h68
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_valid,
  input  logic        reg_write,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        xl_valid,
  input  logic [63:0] xl_addr,
  output logic        res_valid,
  output logic        res_hit,
  output logic        res_miss,
  output logic [1:0]  res_win,
  output logic [63:0] res_pci
);
  localparam int NW     = NFULL + 1;
  localparam int STRIDE = 20;

  logic [63:0] lbase [NFULL];
  logic [63:0] pbase [NFULL];
  logic [31:0] szw   [NW];

  function automatic logic [7:0] ofs(int w, int f);
    return 8'(int'(FIRST_OFS) + STRIDE * w + 4 * f);
  endfunction

  wire wr = reg_valid && reg_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NFULL; w++) begin
        lbase[w] <= '0;
        pbase[w] <= '0;
      end
      for (int w = 0; w < NW; w++) szw[w] <= '0;
    end else if (wr) begin
      for (int w = 0; w < NFULL; w++) begin
        if (reg_addr == ofs(w, 0)) lbase[w][31:0]  <= reg_wdata;
        if (reg_addr == ofs(w, 1)) lbase[w][63:32] <= reg_wdata;
        if (reg_addr == ofs(w, 2)) szw[w]          <= reg_wdata;
        if (reg_addr == ofs(w, 3)) pbase[w][31:0]  <= reg_wdata;
        if (reg_addr == ofs(w, 4)) pbase[w][63:32] <= reg_wdata;
      end
      if (reg_addr == ofs(NFULL, 0)) szw[NFULL] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_valid && !reg_write) begin
      for (int w = 0; w < NFULL; w++) begin
        if (reg_addr == ofs(w, 0)) reg_rdata = lbase[w][31:0];
        if (reg_addr == ofs(w, 1)) reg_rdata = lbase[w][63:32];
        if (reg_addr == ofs(w, 2)) reg_rdata = szw[w];
        if (reg_addr == ofs(w, 3)) reg_rdata = pbase[w][31:0];
        if (reg_addr == ofs(w, 4)) reg_rdata = pbase[w][63:32];
      end
      if (reg_addr == ofs(NFULL, 0)) reg_rdata = szw[NFULL];
    end
  end

  logic [NFULL-1:0] hitv;
  logic [63:0]      xlat [NFULL];

  for (genvar g = 0; g < NFULL; g++) begin : g_win
    wire [31:0] mask = szw[g] & ~32'h1;
    wire [31:0] raw  = ~mask + 32'd1;
    wire [31:0] len  = (raw == 32'd0) ? 32'hFFFF_FFFF : raw;
    wire [64:0] top  = {1'b0, lbase[g]} + {33'd0, len};
    assign hitv[g] = szw[g][0] && (xl_addr >= lbase[g]) && ({1'b0, xl_addr} < top);
    assign xlat[g] = pbase[g] + (xl_addr - lbase[g]);
  end

  logic [1:0]  sel;
  logic [63:0] sel_pci;
  always_comb begin
    sel     = '0;
    sel_pci = '0;
    for (int w = NFULL - 1; w >= 0; w--) begin
      if (hitv[w]) begin
        sel     = 2'(w);
        sel_pci = xlat[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_win   <= '0;
      res_pci   <= '0;
    end else begin
      res_valid <= xl_valid;
      res_hit   <= xl_valid && (|hitv);
      res_miss  <= xl_valid && !(|hitv);
      res_win   <= (xl_valid && (|hitv)) ? sel : 2'd0;
      res_pci   <= (xl_valid && (|hitv)) ? sel_pci : 64'd0;
    end
  end

  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit != res_miss));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_hit && !res_miss));
  a_r8_last_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_win != 2'(NFULL)));
  a_r4_all_off_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && szw[0][0] == 1'b0 && szw[NFULL-1][0] == 1'b0) |=> !res_hit);
  a_r2_low_write_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_addr == ofs(0, 0)) |=> (lbase[0][63:32] == $past(lbase[0][63:32])));
  a_r3_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_valid |-> (reg_rdata == 32'd0));
endmodule

// File: tb/sim_obwin_xlate.sv
module sim_obwin_xlate;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst_n = 0;
  logic        reg_valid = 0, reg_write = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        xl_valid = 0;
  logic [63:0] xl_addr = 0;
  logic        res_valid, res_hit, res_miss;
  logic [1:0]  res_win;
  logic [63:0] res_pci;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [63:0] m_lb [2];
  logic [63:0] m_pb [2];
  logic [31:0] m_sz [2];

  always #(CLK_NS/2) clk = ~clk;

  obwin_xlate u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    #1 chk(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
    reg_valid = 0;
  endtask

  task automatic set_win(input int w, input logic [63:0] lb, input logic [63:0] pb, input logic [31:0] sz);
    logic [7:0] b;
    b = 8'(8'h68 + 20 * w);
    wr(b, lb[31:0]); wr(b + 8'd4, lb[63:32]); wr(b + 8'd8, sz);
    wr(b + 8'd12, pb[31:0]); wr(b + 8'd16, pb[63:32]);
    m_lb[w] = lb; m_pb[w] = pb; m_sz[w] = sz;
  endtask

  function automatic logic [63:0] win_len(input logic [31:0] sz);
    logic [31:0] t;
    t = 32'(33'h1_0000_0000 - {1'b0, sz & 32'hFFFF_FFFE});
    return (t == 0) ? 64'hFFFF_FFFF : {32'd0, t};
  endfunction

  task automatic lookup(input logic [63:0] a, input string req);
    bit eh; int ew; logic [63:0] ep;
    eh = 0; ew = 0; ep = 0;
    for (int w = 1; w >= 0; w--) begin
      if (m_sz[w][0] && a >= m_lb[w] && ({1'b0, a} < {1'b0, m_lb[w]} + {1'b0, win_len(m_sz[w])})) begin
        eh = 1; ew = w; ep = m_pb[w] + (a - m_lb[w]);
      end
    end
    @(negedge clk);
    xl_valid = 1; xl_addr = a;
    @(negedge clk);
    xl_valid = 0;
    chk(res_valid == 1, {req, " R9 valid"}, 64'(res_valid), 1);
    chk(res_hit == eh && res_miss == !eh, {req, " hit"}, 64'(res_hit), 64'(eh));
    if (eh) begin
      chk(res_win == 2'(ew), {req, " R7 win"}, 64'(res_win), 64'(ew));
      chk(res_pci == ep, {req, " R6 pci"}, res_pci, ep);
    end else begin
      chk(res_win == 0 && res_pci == 0, {req, " R9 miss zero"}, res_pci, 0);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] masks [5];
    masks = '{32'hFFFF_F001, 32'hFFFF_0001, 32'hFFF0_0001, 32'h8000_0001, 32'h0000_0001};
    for (int w = 0; w < 2; w++) begin m_lb[w] = 0; m_pb[w] = 0; m_sz[w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int r = 0; r < 11; r++) rd_chk(8'(8'h68 + 4 * r), 0, "R1 reset reg");
    chk(res_valid == 0 && res_hit == 0 && res_miss == 0, "R1 idle outputs", 64'(res_hit), 0);
    lookup(64'h0, "R1 lookup after reset");
    lookup(64'hFFFF_FFFF_0000_0000, "R1 lookup after reset");

    // R2/R3 readback and half writes
    set_win(0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 32'h0);
    rd_chk(8'h68, 32'h3333_4444, "R3 lbase lo"); rd_chk(8'h6C, 32'h1111_2222, "R3 lbase hi");
    rd_chk(8'h74, 32'h7777_8888, "R3 pbase lo"); rd_chk(8'h78, 32'h5555_6666, "R3 pbase hi");
    wr(8'h68, 32'hAAAA_0000);
    rd_chk(8'h6C, 32'h1111_2222, "R2 high kept"); rd_chk(8'h68, 32'hAAAA_0000, "R2 low replaced");
    wr(8'h78, 32'hBBBB_0000);
    rd_chk(8'h74, 32'h7777_8888, "R2 low kept"); rd_chk(8'h78, 32'hBBBB_0000, "R2 high replaced");
    wr(8'h94, 32'hDEAD_BEEF); wr(8'h00, 32'hDEAD_BEEF);
    rd_chk(8'h94, 0, "R3 unmapped read"); rd_chk(8'h00, 0, "R3 unmapped read");
    rd_chk(8'h68, 32'hAAAA_0000, "R3 unmapped write ignored");
    rd_chk(8'h90, 0, "R3 unmapped write ignored");
    set_win(0, 0, 0, 0);

    // R4/R5/R6 sweep per window and size mask
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k < 5; k++) begin
        logic [63:0] lb, len;
        lb = {32'(w + 1), 32'h4000_0000};
        set_win(w, lb, {32'(32'hA0 + w), 32'h0123_0000}, masks[k]);
        rd_chk(8'(8'h70 + 20 * w), masks[k], "R3 size readback");
        len = win_len(masks[k]);
        lookup(lb - 1, "R5 below base");
        lookup(lb, "R5 base");
        lookup(lb + len - 1, "R5 last");
        lookup(lb + len, "R5 past end");
        lookup(lb + (len >> 1), "R6 middle");
        set_win(w, lb, {32'(32'hA0 + w), 32'h0123_0000}, masks[k] & 32'hFFFF_FFFE);
        lookup(lb, "R4 disabled base");
        lookup(lb + 1, "R4 disabled inside");
        set_win(w, 0, 0, 0);
      end
    end

    // R6 wrap modulo 2^64
    set_win(0, 64'h10_0000, 64'hFFFF_FFFF_FFFF_F800, 32'hFFFF_F001);
    lookup(64'h10_0900, "R6 wrap");

    // R7 overlap priority
    set_win(1, 64'h0, 64'h7000_0000, 32'h0000_0001);
    set_win(0, 64'h10_0000, 64'h9000_0000, 32'hFFFF_0001);
    lookup(64'h10_0010, "R7 overlap low wins");
    lookup(64'h20_0000, "R7 only window 1");
    set_win(0, 0, 0, 0); set_win(1, 0, 0, 0);

    // R8 last window size word
    wr(8'h90, 32'hFFFF_F001);
    rd_chk(8'h90, 32'hFFFF_F001, "R8 last size readback");
    lookup(64'h0, "R8 last never hits");
    lookup(64'h800, "R8 last never hits");

    // R10 write and lookup in the same cycle
    set_win(0, 64'h5000, 64'h9_0000_0000, 32'h0);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = 8'h70; reg_wdata = 32'hFFFF_F001;
    xl_valid = 1; xl_addr = 64'h5010;
    @(negedge clk);
    reg_valid = 0; reg_write = 0; xl_valid = 0;
    chk(res_miss == 1 && res_hit == 0, "R10 same-cycle enable sees old", 64'(res_hit), 0);
    m_sz[0] = 32'hFFFF_F001;
    lookup(64'h5010, "R10 next cycle sees new");
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = 8'h70; reg_wdata = 32'h0;
    xl_valid = 1; xl_addr = 64'h5010;
    @(negedge clk);
    reg_valid = 0; reg_write = 0; xl_valid = 0;
    chk(res_hit == 1 && res_pci == 64'h9_0000_0010, "R10 same-cycle disable sees old", res_pci, 64'h9_0000_0010);
    m_sz[0] = 0;
    lookup(64'h5010, "R10 next cycle disabled");

    // R9 idle after lookups
    @(negedge clk);
    chk(res_valid == 0 && res_hit == 0 && res_miss == 0, "R9 idle", 64'(res_valid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule